// File: doc/BRIEF.md
# Selectable-Order PRBS Additive Scrambler

This block whitens a serial bit stream by adding (XOR) each accepted data bit to the next bit of a pseudo-random binary sequence. The sequence comes from a linear feedback shift register whose order is chosen at run time. Five orders are available: 7, 10, 15, 23 and 31. A sequence of order n repeats every 2^n − 1 bits.

The operation is additive, so the same block serves the transmit and receive ends of a link. The receiver loads the same order and seed as the transmitter. It then consumes the scrambled bits in lockstep, and its output is the original data. The mode input tells the two uses apart for reporting only. It is carried to an output beside the data and does not alter the arithmetic.

The order and the seed change together through a single load strobe. A change of the select field alone is never picked up, so the two ends cannot drift apart on a stray select change.

Top module: `prbs_scrambler`

## Requirements
- R1: After a synchronous reset, `gen_state` reads 31'h0000007F (order 7, all ones), and `dout_valid`, `dout` and `dout_descr` are 0.
- R2: For each cycle with `din_valid` high and no accepted load, the generator bit g is s[n-1] XOR s[t-1] of the current state s. The tap pairs (n,t) are (7,6), (10,7), (15,14), (23,18) and (31,28). One clock later, `dout_valid` is 1 and `dout` = `din` XOR g. The state becomes ((s << 1) | g), masked to its low n bits.
- R3: In a cycle with `din_valid` low and no accepted load, `gen_state` does not change, and `dout_valid` is 0 one clock later.
- R4: A load is accepted when `seed_load` is high and `pat_sel` is a valid code. The codes are 0=order 7, 1=order 10, 2=order 15, 3=order 23 and 4=order 31. An accepted load selects that order, and on the next clock `gen_state` equals the low n bits of `seed`, with zeros above bit n-1.
- R5: If the low n bits of the seed are all zero, the accepted load places all ones (n bits) in the generator, so `gen_state` never reads zero.
- R6: A change of `pat_sel` without an accepted load has no effect on the order in use or on the output bits.
- R7: A `seed_load` with `pat_sel` equal to 5, 6 or 7 is ignored, and the cycle behaves as if the strobe were low.
- R8: In a cycle with an accepted load, the data input is not consumed, and `dout_valid` is 0 one clock later.
- R9: After an accepted load of seed S, exactly 2^n − 1 consumed bits bring `gen_state` back to S.
- R10: `descr_mode` has no effect on `dout` or `gen_state`. It appears on `dout_descr` for each consumed bit, with the same one-clock delay as `dout`. Scrambling a stream and then processing the result again from the same seed and order returns the original stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 3 | Order code, sampled only with an accepted load |
| seed_load | input | 1 | Strobe that loads order and seed |
| seed | input | 31 | Seed value; low n bits used |
| din_valid | input | 1 | Input bit qualifier |
| din | input | 1 | Serial input bit |
| descr_mode | input | 1 | 1 = descramble use, 0 = scramble use (reporting only) |
| dout_valid | output | 1 | Output bit qualifier, one clock after input |
| dout | output | 1 | Serial output bit |
| dout_descr | output | 1 | Mode that went with the current output bit |
| gen_state | output | 31 | Generator state, zero above the active order |

## Verification
The hardest behaviour to reach from the ports is the full wrap of a sequence. Checking it takes an unbroken run of 2^n − 1 consumed bits with no intervening load. The bench drives complete periods for orders 7, 10 and 15 and compares the state with the seed at the end. The order-23 and order-31 taps are checked over shorter runs against a bench model. A second hard case is the pairing of a load strobe with an invalid code on a cycle that carries data. This must behave exactly as a data cycle, and the bench drives that combination directly. It also changes the select field while data flows.

// File: rtl/prbs_scrambler.sv
module prbs_scrambler (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  pat_sel,
  input  logic        seed_load,
  input  logic [30:0] seed,
  input  logic        din_valid,
  input  logic        din,
  input  logic        descr_mode,
  output logic        dout_valid,
  output logic        dout,
  output logic        dout_descr,
  output logic [30:0] gen_state
);

  localparam int NPAT = 5;
  localparam int SW   = 31;
  localparam int ORD [NPAT] = '{7, 10, 15, 23, 31};
  localparam int TAP [NPAT] = '{6, 7, 14, 18, 28};

  logic [2:0]    cur_sel;
  logic [SW-1:0] st;
  logic [NPAT-1:0] fb_all;
  logic [SW-1:0] mask_all [NPAT];

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign fb_all[g]   = st[ORD[g]-1] ^ st[TAP[g]-1];
    assign mask_all[g] = SW'((64'd1 << ORD[g]) - 64'd1);
  end

  logic          load_ok;
  logic [2:0]    ld_idx;
  logic [SW-1:0] seed_m, seed_fix, next_st;
  logic          gen_bit;

  assign load_ok  = seed_load && (pat_sel < 3'(NPAT));
  assign ld_idx   = load_ok ? pat_sel : 3'd0;
  assign seed_m   = seed & mask_all[ld_idx];
  assign seed_fix = (seed_m == '0) ? mask_all[ld_idx] : seed_m;
  assign gen_bit  = fb_all[cur_sel];
  assign next_st  = ((st << 1) | SW'(gen_bit)) & mask_all[cur_sel];
  assign gen_state = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= mask_all[0];
      cur_sel    <= 3'd0;
      dout_valid <= 1'b0;
      dout       <= 1'b0;
      dout_descr <= 1'b0;
    end else begin
      dout_valid <= din_valid & ~load_ok;
      if (load_ok) begin
        st      <= seed_fix;
        cur_sel <= pat_sel;
      end else if (din_valid) begin
        st         <= next_st;
        dout       <= din ^ gen_bit;
        dout_descr <= descr_mode;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (din_valid && !load_ok) |=> dout_valid);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!din_valid && !seed_load) |=> ($stable(gen_state) && !dout_valid));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (gen_state & ~mask_all[cur_sel]) == '0);

  p_never_zero_r5: assert property (@(posedge clk) disable iff (rst)
    gen_state != '0);

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !seed_load |=> $stable(cur_sel));

  p_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
    (seed_load && pat_sel >= 3'(NPAT) && !din_valid) |=> ($stable(gen_state) && $stable(cur_sel)));

  p_load_gap_r8: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> !dout_valid);

endmodule

// File: tb/prbs_scrambler_tb.sv
`timescale 1ns/1ps
module prbs_scrambler_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  pat_sel = 3'd0;
  logic        seed_load = 1'b0;
  logic [30:0] seed = '0;
  logic        din_valid = 1'b0;
  logic        din = 1'b0;
  logic        descr_mode = 1'b0;
  logic        dout_valid, dout, dout_descr;
  logic [30:0] gen_state;

  always #2 clk = ~clk;

  prbs_scrambler u_dut (
    .clk(clk), .rst(rst), .pat_sel(pat_sel), .seed_load(seed_load), .seed(seed),
    .din_valid(din_valid), .din(din), .descr_mode(descr_mode),
    .dout_valid(dout_valid), .dout(dout), .dout_descr(dout_descr), .gen_state(gen_state)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [30:0] m_st;
  int          m_sel;

  function automatic int ord(int i);
    case (i) 0: return 7; 1: return 10; 2: return 15; 3: return 23; default: return 31; endcase
  endfunction
  function automatic int tap(int i);
    case (i) 0: return 6; 1: return 7; 2: return 14; 3: return 18; default: return 28; endcase
  endfunction
  function automatic logic [30:0] msk(int i);
    return 31'h7FFFFFFF >> (31 - ord(i));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st  = 31'h7F;
    m_sel = 0;
  endtask

  task automatic cyc(string req, bit v, bit d, bit mode, bit ld, int sel, logic [30:0] sd,
                     output bit got);
    bit ldok, b, expv, expd;
    logic [30:0] sm;
    ldok = ld && sel < 5;
    expv = 0; expd = 0;
    if (ldok) begin
      sm = sd & msk(sel);
      if (sm == 0) sm = msk(sel);
      m_st = sm; m_sel = sel;
    end else if (v) begin
      b = m_st[ord(m_sel)-1] ^ m_st[tap(m_sel)-1];
      m_st = ((m_st << 1) | 31'(b)) & msk(m_sel);
      expd = d ^ b; expv = 1;
    end
    @(negedge clk);
    din_valid = v; din = d; descr_mode = mode; seed_load = ld;
    pat_sel = 3'(sel); seed = sd;
    @(posedge clk); #1;
    chk({req, " valid"}, 32'(dout_valid), 32'(expv));
    if (expv) begin
      chk({req, " data"}, 32'(dout), 32'(expd));
      chk({req, " mode R10"}, 32'(dout_descr), 32'(mode));
    end
    chk({req, " state"}, 32'(gen_state), 32'(m_st));
    got = dout;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; din_valid = 0; seed_load = 0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 31'h0000005A, 16'd60, 1'b0},
    {3'd1, 31'h00000123, 16'd80, 1'b1},
    {3'd2, 31'h00004321, 16'd90, 1'b0},
    {3'd3, 31'h00ABCDEF, 16'd120, 1'b1},
    {3'd4, 31'h12345678, 16'd150, 1'b0},
    {3'd4, 31'h7FFFFFFF, 16'd70, 1'b1}
  };

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit g;
    bit orig [40];
    bit scr [40];
    @(posedge clk); @(posedge clk); #1;
    // R1 reset state
    chk("R1 state", 32'(gen_state), 32'h7F);
    chk("R1 valid", 32'(dout_valid), 0);
    chk("R1 dout", 32'(dout), 0);
    chk("R1 mode", 32'(dout_descr), 0);
    @(negedge clk); rst = 0;
    model_reset();

    // R2 on default order 7 straight out of reset
    for (int i = 0; i < 20; i++) cyc("R2 default", 1, bit'(i % 3 == 0), 0, 0, 0, 0, g);

    // Vector table: load then stream with idle gaps (R2, R3, R4, R8)
    for (int k = 0; k < NV; k++) begin
      int sel = int'(VEC[k][50:48]);
      int nb  = int'(VEC[k][16:1]);
      cyc("R8 R4 load", 1, 1, 0, 1, sel, VEC[k][47:17], g);
      chk("R4 seed", 32'(gen_state), 32'(VEC[k][47:17] & msk(sel)));
      for (int i = 0; i < nb; i++) begin
        if (i % 5 == 4) cyc("R3 idle", 0, 1, VEC[k][0], 0, sel, 0, g);
        else cyc("R2 stream", 1, bit'($urandom_range(1)), VEC[k][0], 0, sel, 0, g);
      end
    end

    // R5 zero seed for order 10 and for order 31
    cyc("R5 load", 0, 0, 0, 1, 1, 31'h7FFFFC00, g);
    chk("R5 ones10", 32'(gen_state), 32'h3FF);
    cyc("R5 load", 0, 0, 0, 1, 4, 31'h0, g);
    chk("R5 ones31", 32'(gen_state), 32'h7FFFFFFF);

    // R6 select change without load is ignored
    cyc("R6 load", 0, 0, 0, 1, 0, 31'h33, g);
    for (int i = 0; i < 30; i++) cyc("R6 sel moves", 1, bit'(i & 1), 0, 0, (i % 7), 0, g);
    chk("R6 width", 32'(gen_state >> 7), 0);

    // R7 invalid code with load strobe, with and without data
    for (int i = 0; i < 6; i++) cyc("R7 bad code", bit'(i & 1), 1, 0, 1, 5 + (i % 3), 31'h1, g);
    chk("R7 still order7", 32'(gen_state >> 7), 0);

    // R9 full periods for orders 7, 10 and 15
    for (int s = 0; s < 3; s++) begin
      logic [30:0] sd;
      int per;
      sd = 31'h15 + 31'(s * 31'h101);
      per = (1 << ord(s)) - 1;
      cyc("R9 load", 0, 0, 0, 1, s, sd, g);
      for (int i = 0; i < per; i++) begin
        cyc("R9 run", 1, 0, 0, 0, s, 0, g);
        if (i == 0) chk("R9 moved", 32'(gen_state != (sd & msk(s))), 1);
      end
      chk("R9 wrap", 32'(gen_state), 32'(sd & msk(s)));
    end

    // R10 round trip: scramble then descramble from same seed
    cyc("R10 load", 0, 0, 0, 1, 3, 31'h2468AC, g);
    for (int i = 0; i < 40; i++) begin
      orig[i] = bit'($urandom_range(1));
      cyc("R10 tx", 1, orig[i], 0, 0, 3, 0, scr[i]);
    end
    cyc("R10 reload", 0, 0, 1, 1, 3, 31'h2468AC, g);
    for (int i = 0; i < 40; i++) begin
      cyc("R10 rx", 1, scr[i], 1, 0, 3, 0, g);
      chk("R10 recover", 32'(g), 32'(orig[i]));
    end

    // R1 reset mid-run
    cyc("R1 pre", 0, 0, 0, 1, 4, 31'h5555, g);
    do_reset();
    #1;
    chk("R1 mid state", 32'(gen_state), 32'h7F);
    chk("R1 mid valid", 32'(dout_valid), 0);
    for (int i = 0; i < 10; i++) cyc("R1 after", 1, 1, 0, 0, 0, 0, g);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule